// File: doc/BRIEF.md
# Converter Control Word Register with Calibration Sequencer

This block is the write-only control word of a data converter's digital core. A parallel word arrives with a two-bit address and a write strobe. Only address `11` selects this register. Each accepted word updates the power-management, read-target, interface-mode and coefficient-select fields. It can also carry two self-clearing commands: start a conversion and start a calibration. The block never returns the word; its fields appear only as decoded outputs.

A calibration command is expanded into an ordered list of steps from the calibration mode bit and the two select bits. A conversion command adds one conversion step, which always runs after any calibration steps. The sequencer works through the steps one at a time. For each step it gives a one-cycle request to the analog core and then waits for that step's done pulse. While no calibration is pending, the select bits instead pick one of four coefficient registers. A completed read cycle drops the interface-mode bit, so keeping that mode needs the bit set again on every write.

Top module: `adc_ctrl_seq`

## Requirements
- R1: After reset, `pwr_mode`, `rd_sel`, `if_mode`, `coef_sel`, `busy`, `cal_err` and every request are 0, and `coef_sel_vld` is 1.
- R2: A write with `wr_addr` = `11` and `wr_data[13:10]` = 0 is accepted. From the next cycle, `pwr_mode` = `wr_data[9:8]`, `rd_sel` = `wr_data[7:6]`, `if_mode` = `wr_data[5]` and `coef_sel` = `wr_data[2:1]`. A write to any other address has no effect.
- R3: A write to address `11` with any of `wr_data[13:10]` nonzero changes no field and starts nothing. It sets `cal_err`, which stays 1 until reset.
- R4: A `rd_done` pulse clears `if_mode` on the next cycle. If an accepted write happens in the same cycle, the written value wins.
- R5: In an accepted write, `wr_data[4]` = 1 starts one conversion. `conv_req` pulses in the cycle after the write. The command clears itself when `conv_done` arrives.
- R6: In an accepted write, `wr_data[0]` = 1 starts a calibration whose steps are chosen by `wr_data[2:1]`:
  - `00`: DAC, then gain, then offset.
  - `01`: gain, then offset.
  - `10`: offset only.
  - `11`: gain only.
- R7: `wr_data[3]` = 0 makes the gain and offset steps internal (`gain_int_req`, `offs_int_req`). `wr_data[3]` = 1 makes them system steps (`gain_sys_req`, `offs_sys_req`). The DAC step always uses `dac_req`.
- R8: At most one request is high at a time, and each request lasts exactly one cycle. The next step is requested in the cycle after the current step's done pulse. Done pulses for any other step are ignored.
- R9: `busy` is 1 from the cycle after a starting write until the cycle after the last step's done pulse. No request is raised while `busy` is 0.
- R10: An accepted write that sets a start bit while `busy` is 1 starts nothing. Its other fields still update.
- R11: When both start bits are set in one write, all calibration steps run first and the conversion step runs last.
- R12: `coef_sel_vld` is 0 while calibration steps are pending and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Register address; `11` selects this register |
| wr_data | input | 14 | Control word |
| rd_done | input | 1 | Read cycle complete pulse |
| dac_done | input | 1 | DAC calibration step finished |
| gain_done | input | 1 | Gain calibration step finished |
| offs_done | input | 1 | Offset calibration step finished |
| conv_done | input | 1 | Conversion finished |
| pwr_mode | output | 2 | Power-management field |
| rd_sel | output | 2 | Read target select |
| if_mode | output | 1 | Interface-mode bit |
| coef_sel | output | 2 | Coefficient register select |
| coef_sel_vld | output | 1 | Coefficient select is in force (no calibration pending) |
| busy | output | 1 | Step sequence in progress |
| cal_err | output | 1 | Sticky reserved-bit write error |
| dac_req | output | 1 | DAC calibration request |
| gain_int_req | output | 1 | Internal gain calibration request |
| gain_sys_req | output | 1 | System gain calibration request |
| offs_int_req | output | 1 | Internal offset calibration request |
| offs_sys_req | output | 1 | System offset calibration request |
| conv_req | output | 1 | Conversion request |

## Verification
A pending mask that is wrong shows up on the request outputs. A step may be missing, appear twice or come in the wrong order, and `busy` may drop early or stay high. This is visible at the first request or done pulse after the fault, never more than one cycle late. A wrong field register shows on its output in the cycle after the write or read completion. A lost internal/system flag changes which request line pulses for the first gain or offset step.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  localparam int DATA_W   = 14;
  localparam int ADDR_W   = 2;
  localparam int N_STEP   = 4;
  localparam int N_CAL    = N_STEP - 1;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '1;

  // field positions inside the control word
  localparam int B_STCAL  = 0;
  localparam int B_SEL_LO = 1;
  localparam int B_CALMD  = 3;
  localparam int B_CONV   = 4;
  localparam int B_IFM    = 5;
  localparam int B_RD_LO  = 6;
  localparam int B_PM_LO  = 8;
  localparam int B_RSV_LO = 10;
  localparam int RSV_W    = DATA_W - B_RSV_LO;

  // step index = execution priority (lowest first)
  typedef enum logic [1:0] {
    STP_DAC  = 2'd0,
    STP_GAIN = 2'd1,
    STP_OFFS = 2'd2,
    STP_CONV = 2'd3
  } step_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_REQ  = 2'd1,
    PH_WAIT = 2'd2
  } phase_e;

  typedef struct packed {
    logic [1:0] pm;
    logic [1:0] rd;
    logic       ifm;
    logic [1:0] sel;
  } ctrl_fields_t;
endpackage

// File: rtl/adc_ctrl_decode.sv
module adc_ctrl_decode
  import adc_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_done,
  output ctrl_fields_t      fields,
  output logic              go_conv,
  output logic              go_cal,
  output logic              go_sys,
  output logic              err
);
  ctrl_fields_t fields_q, fields_d;
  logic         err_q, err_d;
  logic         hit, rsv_bad, acc;

  assign hit     = wr_en && (wr_addr == CTRL_ADDR);
  assign rsv_bad = |wr_data[B_RSV_LO +: RSV_W];
  assign acc     = hit && !rsv_bad;

  always_comb begin
    fields_d = fields_q;
    err_d    = err_q;
    if (hit && rsv_bad) err_d = 1'b1;
    if (acc) begin
      fields_d.pm  = wr_data[B_PM_LO +: 2];
      fields_d.rd  = wr_data[B_RD_LO +: 2];
      fields_d.ifm = wr_data[B_IFM];
      fields_d.sel = wr_data[B_SEL_LO +: 2];
    end else if (rd_done) begin
      fields_d.ifm = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fields_q <= '0;
      err_q    <= 1'b0;
    end else begin
      fields_q <= fields_d;
      err_q    <= err_d;
    end
  end

  assign fields  = fields_q;
  assign err     = err_q;
  assign go_conv = acc && wr_data[B_CONV];
  assign go_cal  = acc && wr_data[B_STCAL];
  assign go_sys  = wr_data[B_CALMD];
endmodule

// File: rtl/adc_ctrl_plan.sv
module adc_ctrl_plan
  import adc_ctrl_pkg::*;
(
  input  logic              cal_go,
  input  logic              conv_go,
  input  logic [1:0]        sel,
  output logic [N_STEP-1:0] mask
);
  always_comb begin
    mask           = '0;
    mask[STP_DAC]  = cal_go && (sel == 2'b00);
    mask[STP_GAIN] = cal_go && (sel != 2'b10);
    mask[STP_OFFS] = cal_go && (sel != 2'b11);
    mask[STP_CONV] = conv_go;
  end
endmodule

// File: rtl/adc_ctrl_seq_core.sv
module adc_ctrl_seq_core
  import adc_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic [N_STEP-1:0] launch_mask,
  input  logic              launch_sys,
  input  logic [N_STEP-1:0] done,
  output logic [N_STEP-1:0] step_req,
  output logic              sys,
  output logic              busy,
  output logic              cal_active
);
  logic [N_STEP-1:0] pend_q, pend_d, cur, left;
  phase_e            ph_q, ph_d;
  logic              sys_q, sys_d;

  // lowest pending bit is the step in progress
  assign cur  = pend_q & (~pend_q + 1'b1);
  assign left = pend_q & ~cur;

  always_comb begin
    pend_d = pend_q;
    ph_d   = ph_q;
    sys_d  = sys_q;
    unique case (ph_q)
      PH_IDLE: if (launch && (launch_mask != '0)) begin
        pend_d = launch_mask;
        sys_d  = launch_sys;
        ph_d   = PH_REQ;
      end
      PH_REQ:  ph_d = PH_WAIT;
      PH_WAIT: if ((done & cur) != '0) begin
        pend_d = left;
        ph_d   = (left != '0) ? PH_REQ : PH_IDLE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      ph_q   <= PH_IDLE;
      sys_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ph_q   <= ph_d;
      sys_q  <= sys_d;
    end
  end

  assign step_req   = (ph_q == PH_REQ) ? cur : '0;
  assign busy       = (ph_q != PH_IDLE);
  assign sys        = sys_q;
  assign cal_active = |pend_q[N_CAL-1:0];
endmodule

// File: rtl/adc_ctrl_seq.sv
module adc_ctrl_seq
  import adc_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_done,
  input  logic              dac_done,
  input  logic              gain_done,
  input  logic              offs_done,
  input  logic              conv_done,
  output logic [1:0]        pwr_mode,
  output logic [1:0]        rd_sel,
  output logic              if_mode,
  output logic [1:0]        coef_sel,
  output logic              coef_sel_vld,
  output logic              busy,
  output logic              cal_err,
  output logic              dac_req,
  output logic              gain_int_req,
  output logic              gain_sys_req,
  output logic              offs_int_req,
  output logic              offs_sys_req,
  output logic              conv_req
);
  ctrl_fields_t      fld;
  logic              go_conv, go_cal, go_sys, launch, sys, cal_active;
  logic [N_STEP-1:0] mask, done_v, step_req;

  adc_ctrl_decode u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_done(rd_done), .fields(fld),
    .go_conv(go_conv), .go_cal(go_cal), .go_sys(go_sys), .err(cal_err)
  );

  adc_ctrl_plan u_plan (
    .cal_go(go_cal), .conv_go(go_conv), .sel(wr_data[B_SEL_LO +: 2]),
    .mask(mask)
  );

  // start commands are dropped while a sequence runs
  assign launch = (go_cal || go_conv) && !busy;
  assign done_v = {conv_done, offs_done, gain_done, dac_done};

  adc_ctrl_seq_core u_core (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_mask(mask),
    .launch_sys(go_sys), .done(done_v), .step_req(step_req), .sys(sys),
    .busy(busy), .cal_active(cal_active)
  );

  assign pwr_mode     = fld.pm;
  assign rd_sel       = fld.rd;
  assign if_mode      = fld.ifm;
  assign coef_sel     = fld.sel;
  assign coef_sel_vld = !cal_active;

  assign dac_req      = step_req[STP_DAC];
  assign gain_int_req = step_req[STP_GAIN] && !sys;
  assign gain_sys_req = step_req[STP_GAIN] &&  sys;
  assign offs_int_req = step_req[STP_OFFS] && !sys;
  assign offs_sys_req = step_req[STP_OFFS] &&  sys;
  assign conv_req     = step_req[STP_CONV];
endmodule

// File: rtl/adc_ctrl_seq_chk.sv
module adc_ctrl_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic [13:0] wr_data,
  input logic        rd_done,
  input logic [1:0]  pwr_mode,
  input logic        if_mode,
  input logic        coef_sel_vld,
  input logic        busy,
  input logic        cal_err,
  input logic        dac_req,
  input logic        gain_int_req,
  input logic        gain_sys_req,
  input logic        offs_int_req,
  input logic        offs_sys_req,
  input logic        conv_req
);
  logic [5:0] reqs;
  logic       bad_wr, good_wr;
  assign reqs    = {conv_req, offs_sys_req, offs_int_req, gain_sys_req, gain_int_req, dac_req};
  assign bad_wr  = wr_en && (wr_addr == 2'b11) && (wr_data[13:10] != 4'd0);
  assign good_wr = wr_en && (wr_addr == 2'b11) && (wr_data[13:10] == 4'd0);

  // R8
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(reqs));
  // R8
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) (reqs != 6'd0) |=> (reqs == 6'd0));
  // R9
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (reqs == 6'd0));
  // R3
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) cal_err |=> cal_err);
  // R3
  bad_wr_chk: assert property (@(posedge clk) disable iff (!rst_n) bad_wr |=> (cal_err && $stable(pwr_mode)));
  // R4
  rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n) (rd_done && !good_wr) |=> !if_mode);
  // R12
  vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_req || gain_int_req || gain_sys_req || offs_int_req || offs_sys_req) |-> !coef_sel_vld);
endmodule

bind adc_ctrl_seq adc_ctrl_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_done(rd_done), .pwr_mode(pwr_mode), .if_mode(if_mode),
  .coef_sel_vld(coef_sel_vld), .busy(busy), .cal_err(cal_err),
  .dac_req(dac_req), .gain_int_req(gain_int_req), .gain_sys_req(gain_sys_req),
  .offs_int_req(offs_int_req), .offs_sys_req(offs_sys_req), .conv_req(conv_req)
);

// File: tb/adc_ctrl_seq_tb.sv
module adc_ctrl_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'b00;
  logic [13:0] wr_data = '0;
  logic        rd_done = 1'b0;
  logic [3:0]  dn = 4'd0;  // {conv, offs, gain, dac}
  logic [1:0]  pwr_mode, rd_sel, coef_sel;
  logic        if_mode, coef_sel_vld, busy, cal_err;
  logic        dac_req, gain_int_req, gain_sys_req, offs_int_req, offs_sys_req, conv_req;
  logic [5:0]  reqvec;

  int compared = 0;
  int mismatched = 0;
  int exp_codes[4];
  int exp_n;

  always #5 clk = ~clk;

  adc_ctrl_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_done(rd_done), .dac_done(dn[0]), .gain_done(dn[1]), .offs_done(dn[2]),
    .conv_done(dn[3]), .pwr_mode(pwr_mode), .rd_sel(rd_sel), .if_mode(if_mode),
    .coef_sel(coef_sel), .coef_sel_vld(coef_sel_vld), .busy(busy), .cal_err(cal_err),
    .dac_req(dac_req), .gain_int_req(gain_int_req), .gain_sys_req(gain_sys_req),
    .offs_int_req(offs_int_req), .offs_sys_req(offs_sys_req), .conv_req(conv_req)
  );

  // request codes: 0 dac, 1 gain int, 2 gain sys, 3 offs int, 4 offs sys, 5 conv
  assign reqvec = {conv_req, offs_sys_req, offs_int_req, gain_sys_req, gain_int_req, dac_req};

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  function automatic logic [13:0] mk(input logic [1:0] pm, input logic [1:0] rd,
      input logic ifm, input logic cv, input logic md, input logic [1:0] sel, input logic cal);
    return {4'b0000, pm, rd, ifm, cv, md, sel, cal};
  endfunction

  function automatic int done_idx(input int code);
    case (code)
      0: return 0;
      1, 2: return 1;
      3, 4: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic plan_seq(input logic md, input logic [1:0] sel, input logic cal, input logic cv);
    int g = md ? 2 : 1;
    int o = md ? 4 : 3;
    exp_n = 0;
    if (cal) begin
      case (sel)
        2'b00: begin exp_codes[0] = 0; exp_codes[1] = g; exp_codes[2] = o; exp_n = 3; end
        2'b01: begin exp_codes[0] = g; exp_codes[1] = o; exp_n = 2; end
        2'b10: begin exp_codes[0] = o; exp_n = 1; end
        default: begin exp_codes[0] = g; exp_n = 1; end
      endcase
    end
    if (cv) begin exp_codes[exp_n] = 5; exp_n++; end
  endtask

  task automatic wr(input logic [1:0] a, input logic [13:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // serve expected steps; entered at a negedge just after the starting write
  task automatic service(input string tag);
    for (int i = 0; i < exp_n; i++) begin
      int w = 0;
      int di = done_idx(exp_codes[i]);
      while (reqvec == 6'd0 && w < 40) begin @(negedge clk); w++; end
      check(32'(reqvec), 32'(6'd1 << exp_codes[i]), {tag, " R6 R7 R11 step order"});
      @(negedge clk);
      check(32'(reqvec), 32'd0, "R8 request lasts one cycle");
      if ($urandom_range(0, 1) == 1) begin
        dn[(di + 1 + $urandom_range(0, 2)) % 4] = 1'b1;
        @(negedge clk);
        dn = 4'd0;
        check(32'(busy), 32'd1, "R8 foreign done ignored");
        check(32'(reqvec), 32'd0, "R8 no step advance on foreign done");
      end
      dn[di] = 1'b1;
      @(negedge clk);
      dn = 4'd0;
      check(32'(busy), (i == exp_n - 1) ? 32'd0 : 32'd1, "R9 busy span");
    end
  endtask

  initial begin
    logic [1:0] m_pm, m_rd, m_sel;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(32'({pwr_mode, rd_sel, if_mode, coef_sel}), 32'd0, "R1 fields");
    check(32'({busy, cal_err}), 32'd0, "R1 busy/err");
    check(32'(reqvec), 32'd0, "R1 requests");
    check(32'(coef_sel_vld), 32'd1, "R1 coef_sel_vld");

    // R2 plain field write, then wrong address ignored
    wr(2'b11, mk(2'b10, 2'b01, 1'b1, 1'b0, 1'b0, 2'b11, 1'b0));
    check(32'({pwr_mode, rd_sel, if_mode, coef_sel}), 32'b10_01_1_11, "R2 field decode");
    wr(2'b01, mk(2'b01, 2'b10, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1));
    check(32'({pwr_mode, rd_sel, if_mode, coef_sel}), 32'b10_01_1_11, "R2 other address ignored");
    check(32'(busy), 32'd0, "R2 other address starts nothing");

    // R3 reserved bits nonzero
    wr(2'b11, 14'b0100_00_00_0_1_0_00_1);
    check(32'({pwr_mode, rd_sel, if_mode, coef_sel}), 32'b10_01_1_11, "R3 write ignored");
    check(32'(busy), 32'd0, "R3 no start");
    check(32'(cal_err), 32'd1, "R3 error set");
    wr(2'b11, mk(2'b00, 2'b00, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0));
    check(32'(cal_err), 32'd1, "R3 error sticky");

    // R4 write and read completion in the same cycle: write wins
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'b11; wr_data = mk(2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0);
    rd_done = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_done = 1'b0;
    check(32'(if_mode), 32'd1, "R4 write beats read completion");
    rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
    check(32'(if_mode), 32'd0, "R4 read completion clears mode");

    // R5 conversion only
    wr(2'b11, mk(2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0));
    check(32'(conv_req), 32'd1, "R5 conv_req in cycle after write");
    check(32'(busy), 32'd1, "R9 busy after write");
    plan_seq(1'b0, 2'b00, 1'b0, 1'b1);
    service("R5");

    // R10 start while busy: offset-only cal, then a write with conv and new power bits
    wr(2'b11, mk(2'b01, 2'b00, 1'b0, 1'b0, 1'b1, 2'b10, 1'b1));
    check(32'(offs_sys_req), 32'd1, "R7 system offset request");
    check(32'(coef_sel_vld), 32'd0, "R12 select not in force during cal");
    wr(2'b11, mk(2'b11, 2'b10, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1));
    check(32'({pwr_mode, rd_sel}), 32'b11_10, "R10 other fields update while busy");
    check(32'(busy), 32'd1, "R10 still busy");
    dn[2] = 1'b1;
    @(negedge clk);
    dn = 4'd0;
    check(32'(busy), 32'd0, "R10 ignored start bits add no step");
    repeat (3) begin
      @(negedge clk);
      check(32'(reqvec), 32'd0, "R10 no conversion started");
    end
    check(32'(coef_sel_vld), 32'd1, "R12 select in force when idle");

    // R11 full internal cal plus conversion
    wr(2'b11, mk(2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1));
    plan_seq(1'b0, 2'b00, 1'b1, 1'b1);
    service("R11");

    // random mix
    for (int it = 0; it < 60; it++) begin
      logic ifm, cv, md, cal;
      m_pm = 2'($urandom_range(0, 3));
      m_rd = 2'($urandom_range(0, 3));
      m_sel = 2'($urandom_range(0, 3));
      ifm = 1'($urandom_range(0, 1));
      cv = 1'($urandom_range(0, 1));
      md = 1'($urandom_range(0, 1));
      cal = 1'($urandom_range(0, 1));
      wr(2'b11, mk(m_pm, m_rd, ifm, cv, md, m_sel, cal));
      check(32'({pwr_mode, rd_sel, if_mode, coef_sel}), 32'({m_pm, m_rd, ifm, m_sel}), "R2 random fields");
      check(32'(busy), 32'(cal | cv), "R9 busy follows start bits");
      check(32'(coef_sel_vld), 32'(!cal), "R12 random select validity");
      plan_seq(md, m_sel, cal, cv);
      service("R6 random");
      if ($urandom_range(0, 1) == 1) begin
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
        check(32'(if_mode), 32'd0, "R4 random read completion");
      end
    end
    finish_run();
  end
endmodule